// File: doc/BRIEF.md
# Ternary Match Array

A small content-addressable store built entirely from flip-flops. Each of its entries holds a data word and a care mask of the same width. Every cycle the block compares one search key against all entries in parallel. It returns a vector with one hit bit per entry.

A bit position whose care bit is 0 is a wildcard for that entry. This makes the array suited to prefix or field lookups, such as route tables or classification rules. Several entries may hit the same key at once. The raw hit vector goes to the consumer, which applies any priority it needs.

Entries are loaded one per clock through a simple addressed write port. A validity flag on each entry keeps entries that were never loaded from hitting. The hit vector is registered.

Top module: `ternary_match_array`

## Requirements
- R1: A synchronous active-high `rst` clears the hit vector. In the cycle after a reset edge, `hit_vec` is all zeros.
- R2: An entry that has not been written since the last reset never sets its hit bit, for any search key. This holds even for the all-zeros and all-ones keys.
- R3: An entry hits when, at every bit position where its stored care bit is 1, the key bit equals the stored data bit.
- R4: Bit positions whose stored care bit is 0 have no effect on the result. Data bits written under a care bit of 0 are also ignored. An entry written with an all-zero care mask hits every key.
- R5: `hit_vec` bit i reports entry i. Any number of bits may be set at once. Entries with overlapping prefixes both report a hit.
- R6: The key present before a rising edge produces its hit vector after that edge: exactly one register stage. With writes idle and the key held, `hit_vec` stays constant.
- R7: When `wr_en` is 1 at a rising edge, the entry at `wr_addr` takes `wr_data` and `wr_care` together and becomes valid. When `wr_en` is 0, no entry changes. An address of `ENTRIES` or above writes nothing.
- R8: When a write and a search fall in the same cycle, the search sees the entry contents from before that write.
- R9: A second write to an already valid entry fully replaces its data and care mask.
- R10: A reset applied after entries were loaded invalidates all of them, so every key misses until new writes arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one entry |
| wr_addr | input | ADDR_W | Entry index to load |
| wr_data | input | DATA_W | Data word to store |
| wr_care | input | DATA_W | Care mask to store, 1 means compared |
| srch_key | input | DATA_W | Search key, one per cycle |
| hit_vec | output | ENTRIES | Registered hit bit for each entry |

## Verification
The bench searches all-zeros and all-ones keys before any write. A design that let an empty entry take part would hit there, because an entry with a zero mask matches everything.

It writes garbage data under masked bits and searches keys that differ only in wildcard positions. A design that compared stored data without the mask would miss those keys.

It issues writes and searches in the same cycle. A design that forwarded the new contents would report a hit one cycle early.

It loads nested prefixes and expects both hits, which catches any hidden priority logic. It also resets mid-run and checks that every stale entry goes quiet.

// File: rtl/tma_pkg.sv
package tma_pkg;

   // Selects which storage flops the synchronous reset reaches.
   typedef enum logic {
      TMA_CLEAR_ALL   = 1'b0,  // valid flag, data and care mask all cleared
      TMA_CLEAR_VALID = 1'b1   // only the valid flag is cleared; payload flops have no reset
   } tma_clear_e;

endpackage

// File: rtl/tma_wr_decode.sv
module tma_wr_decode #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [ENTRIES-1:0] wr_sel
);

   always_comb begin
      wr_sel = '0;
      if (wr_en && (32'(wr_addr) < ENTRIES))
         wr_sel[wr_addr] = 1'b1;
   end

endmodule

// File: rtl/tma_entry.sv
module tma_entry #(
   parameter int unsigned          DATA_W     = 32,
   parameter tma_pkg::tma_clear_e  CLEAR_MODE = tma_pkg::TMA_CLEAR_ALL
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] wr_care,
   input  logic [DATA_W-1:0] key,
   output logic              hit
);

   logic              valid_q;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] care_q;
   logic [DATA_W-1:0] diff;

   always_ff @(posedge clk) begin
      if (rst)
         valid_q <= 1'b0;
      else if (load)
         valid_q <= 1'b1;
   end

   generate
      if (CLEAR_MODE == tma_pkg::TMA_CLEAR_ALL) begin : g_clear_all
         always_ff @(posedge clk) begin
            if (rst) begin
               data_q <= '0;
               care_q <= '0;
            end else if (load) begin
               data_q <= wr_data;
               care_q <= wr_care;
            end
         end
      end else begin : g_clear_valid
         always_ff @(posedge clk) begin
            if (load) begin
               data_q <= wr_data;
               care_q <= wr_care;
            end
         end
      end
   endgenerate

   // Masked mismatch: only bits with care set can break the match.
   assign diff = (key ^ data_q) & care_q;
   assign hit  = valid_q & ~(|diff);

endmodule

// File: rtl/tma_hit_reg.sv
module tma_hit_reg #(
   parameter int unsigned ENTRIES = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ENTRIES-1:0] hit_d,
   output logic [ENTRIES-1:0] hit_q
);

   always_ff @(posedge clk) begin
      if (rst)
         hit_q <= '0;
      else
         hit_q <= hit_d;
   end

endmodule

// File: rtl/ternary_match_array.sv
module ternary_match_array #(
   parameter int unsigned         DATA_W     = 32,
   parameter int unsigned         ENTRIES    = 16,
   parameter tma_pkg::tma_clear_e CLEAR_MODE = tma_pkg::TMA_CLEAR_ALL,
   localparam int unsigned        ADDR_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [DATA_W-1:0]  wr_care,
   input  logic [DATA_W-1:0]  srch_key,
   output logic [ENTRIES-1:0] hit_vec
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("ternary_match_array: DATA_W must be at least 1");
      end
      if (ENTRIES < 2) begin : g_bad_depth
         $error("ternary_match_array: ENTRIES must be at least 2");
      end
   endgenerate

   logic [ENTRIES-1:0] wr_sel;
   logic [ENTRIES-1:0] hit_raw;

   tma_wr_decode #(
      .ENTRIES (ENTRIES),
      .ADDR_W  (ADDR_W)
   ) u_dec (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_sel  (wr_sel)
   );

   generate
      for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_entry
         tma_entry #(
            .DATA_W     (DATA_W),
            .CLEAR_MODE (CLEAR_MODE)
         ) u_ent (
            .clk     (clk),
            .rst     (rst),
            .load    (wr_sel[gi]),
            .wr_data (wr_data),
            .wr_care (wr_care),
            .key     (srch_key),
            .hit     (hit_raw[gi])
         );
      end
   endgenerate

   tma_hit_reg #(
      .ENTRIES (ENTRIES)
   ) u_hreg (
      .clk   (clk),
      .rst   (rst),
      .hit_d (hit_raw),
      .hit_q (hit_vec)
   );

endmodule

// File: rtl/tma_chk.sv
module tma_chk #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned ADDR_W  = 4
) (
   input logic               clk,
   input logic               rst,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [DATA_W-1:0]  wr_data,
   input logic [DATA_W-1:0]  wr_care,
   input logic [DATA_W-1:0]  srch_key,
   input logic [ENTRIES-1:0] hit_vec
);

   // Shadow of which entries have been written since reset, built from ports only.
   logic [ENTRIES-1:0] seen_q;

   always_ff @(posedge clk) begin
      if (rst)
         seen_q <= '0;
      else if (wr_en && (32'(wr_addr) < ENTRIES))
         seen_q[wr_addr] <= 1'b1;
   end

   // R1: the cycle after a reset edge shows an empty hit vector
   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (hit_vec == '0));

   // R2: no hit bit for an entry never written since reset
   assert_unwritten_silent_R2: assert property (@(posedge clk) disable iff (rst)
      ((hit_vec & ~$past(seen_q)) == '0));

   // R6: idle writes and a held key keep the hit vector steady
   assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
      ($stable(srch_key) && !$past(wr_en) && !$past(rst)) |=> $stable(hit_vec));

   // R4: an entry loaded with an all-zero care mask hits the next search
   assert_dontcare_entry_hits_R4: assert property (@(posedge clk) disable iff (rst)
      ($past(wr_en) && ($past(wr_care) == '0) && !$past(rst) &&
       (32'($past(wr_addr)) < ENTRIES)) |=> hit_vec[$past(wr_addr, 2)]);

endmodule

bind ternary_match_array tma_chk #(
   .DATA_W  (DATA_W),
   .ENTRIES (ENTRIES),
   .ADDR_W  (ADDR_W)
) u_chk (.*);

// File: tb/test_ternary_match_array.sv
`timescale 1ns/1ps
module test_ternary_match_array;

   localparam int DW = 32;
   localparam int NE = 16;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic [DW-1:0] wr_care;
   logic [DW-1:0] srch_key;
   logic [NE-1:0] hit_vec;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   logic [DW-1:0] m_data [NE];
   logic [DW-1:0] m_care [NE];
   logic [NE-1:0] m_valid;

   ternary_match_array #(.DATA_W(DW), .ENTRIES(NE)) i_ternary_match_array (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_care(wr_care), .srch_key(srch_key), .hit_vec(hit_vec)
   );

   always #5 clk = ~clk;

   function automatic logic [NE-1:0] model_hits(input logic [DW-1:0] key);
      logic [NE-1:0] r = '0;
      for (int i = 0; i < NE; i++)
         r[i] = m_valid[i] && (((key ^ m_data[i]) & m_care[i]) == '0);
      return r;
   endfunction

   function automatic logic [DW-1:0] prefix_mask(input int len);
      return ~(32'hFFFF_FFFF >> len);
   endfunction

   task automatic check(input string req, input logic [NE-1:0] exp);
      n_tests++;
      if (hit_vec !== exp) begin
         n_fail++;
         $display("FAIL %s: hit_vec=%h expected=%h", req, hit_vec, exp);
      end
   endtask

   // Drive one cycle at a falling edge; compare one clock later.
   task automatic step(input string req, input bit we, input int addr,
                       input logic [DW-1:0] d, input logic [DW-1:0] c,
                       input logic [DW-1:0] key);
      logic [NE-1:0] exp;
      wr_en    = we;
      wr_addr  = AW'(addr);
      wr_data  = d;
      wr_care  = c;
      srch_key = key;
      exp = model_hits(key);              // search sees pre-write contents (R8)
      if (we && addr < NE) begin
         m_data[addr]  = d;
         m_care[addr]  = c;
         m_valid[addr] = 1'b1;
      end
      @(negedge clk);
      check(req, exp);
   endtask

   task automatic do_reset();
      rst = 1'b1; wr_en = 1'b0;
      m_valid = '0;
      @(negedge clk);
      @(negedge clk);
      check("R1", '0);
      rst = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd2024));
      rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_care = '0; srch_key = '0;
      m_valid = '0;
      for (int i = 0; i < NE; i++) begin m_data[i] = '0; m_care[i] = '0; end
      @(negedge clk);
      do_reset();

      // R2: empty array, extreme keys
      step("R2", 0, 0, '0, '0, 32'h0000_0000);
      step("R2", 0, 0, '0, '0, 32'hFFFF_FFFF);
      check("R2", 16'h0000);

      // R7: wr_en low changes nothing
      step("R7", 0, 3, 32'h0, 32'h0, 32'h1357_9BDF);
      step("R7", 0, 3, 32'h0, 32'h0, 32'h0);
      check("R7", 16'h0000);

      // Nested prefixes: 16-bit at entry 4, 24-bit at entry 5, 12-bit at entry 11
      step("R7", 1, 4,  32'hC0A8_0000, prefix_mask(16), 32'h0);
      step("R7", 1, 5,  32'hC0A8_0100, prefix_mask(24), 32'h0);
      step("R4", 1, 11, 32'h7E0D_EAD5, prefix_mask(12), 32'h0);  // junk under wildcards
      step("R5", 0, 0, '0, '0, 32'hC0A8_01FE);
      check("R5", 16'h0030);
      step("R3", 0, 0, '0, '0, 32'hC0A8_02FE);
      check("R3", 16'h0010);
      step("R3", 0, 0, '0, '0, 32'hC0A9_0100);
      check("R3", 16'h0000);
      step("R4", 0, 0, '0, '0, 32'h7E01_2345);
      check("R4", 16'h0800);

      // R6: key change shows after one edge
      step("R6", 0, 0, '0, '0, 32'hC0A8_0101);
      check("R6", 16'h0030);

      // R8: write and search same cycle
      step("R8", 1, 7, 32'h0, 32'h0, 32'h5555_5555);
      check("R8", 16'h0000);
      step("R4", 0, 0, '0, '0, 32'h5555_5555);
      check("R4", 16'h0080);

      // R9: overwrite entry 4 with an exact match
      step("R9", 1, 4, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'h0);
      step("R9", 0, 0, '0, '0, 32'hC0A8_0001);
      check("R9", 16'h0080);
      step("R9", 0, 0, '0, '0, 32'hDEAD_BEEF);
      check("R9", 16'h0090);

      // R10: reset after loading
      do_reset();
      step("R10", 0, 0, '0, '0, 32'hDEAD_BEEF);
      step("R10", 0, 0, '0, '0, 32'h5555_5555);
      check("R10", 16'h0000);

      // Random phase
      for (int n = 0; n < 400; n++) begin
         int a = int'($urandom_range(NE - 1));
         int pick = int'($urandom_range(NE - 1));
         logic [DW-1:0] c = ($urandom_range(3) == 0) ? DW'($urandom)
                                                     : prefix_mask(int'($urandom_range(32)));
         logic [DW-1:0] k = m_data[pick] ^ (DW'($urandom) & ~m_care[pick]);
         if ($urandom_range(4) == 0) k = k ^ (DW'(1) << $urandom_range(31));
         step("R3", ($urandom_range(2) == 0), a, DW'($urandom), c, k);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule